// File: doc/BRIEF.md
# Tri-State PWM Gate Sequencer

This block turns a three-level PWM indication into the two gate commands of a synchronous buck half-bridge. External comparators reduce the PWM pin voltage to a two-bit level code: firmly low, firmly high, or inside the middle hysteresis window. A firm high commands the high-side gate. A firm low commands the low-side gate. A level that stays in the middle window longer than a hold-off time is taken as a floating controller output, and both gates are parked off.

Once parked, the stage resumes switching only after a firm high level. A return to low is not enough. The stage also comes out of reset parked. An enable from a protection supervisor can force both gates off at any time.

In diode-emulation mode, selected by an active-low mode input, the low-side gate is cut as soon as a zero-crossing flag reports that the inductor current has reached zero. The cut is latched until the next firm high. A programmable dead time keeps the two gates apart on every transition.

Top module: `tgc_gate_ctrl`

## Requirements
- R1: The level code is 2'b00 low, 2'b10 high, and 2'b01 or 2'b11 mid. When a code is sampled on a clock edge and the stage is active, the gate it selects turns on at the next edge, unless the dead time still delays it. High selects gh_o and low selects gl_o. A mid code keeps the last firm phase.
- R2: When HOLDOFF_CYC consecutive mid samples have been taken, the stage parks. Both gates are then low from the second edge after the last of those samples. Any non-mid sample restarts the count, so a shorter mid run does not disturb switching.
- R3: While parked, low codes do not resume switching. Only a high sample clears the parked state.
- R4: After reset, the stage is parked, with both gates low. It stays parked until the first high sample, even when the input is low.
- R5: With de_en_ni high (continuous conduction), gl_o stays on for the whole low phase, whatever zero_cross_i does.
- R6: With de_en_ni low, a zero_cross_i sample taken during the low phase cuts gl_o from the second edge after that sample. The cut holds while the flag is later deasserted, and it is cleared only by a high sample or by de_en_ni going high.
- R7: When enable_i is sampled low, both gates are low after the next edge. The parked state and the phase are left unchanged.
- R8: gh_o and gl_o are never high together.
- R9: A gate turns on only after both gates have been low for DEAD_CYC+1 consecutive cycles. The opposite gate therefore rises DEAD_CYC+1 cycles after the other falls, when its request persists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 2 | Digitised PWM level code |
| enable_i | input | 1 | Supervisor enable, active high |
| de_en_ni | input | 1 | Diode-emulation enable, active low |
| zero_cross_i | input | 1 | Inductor current has reached zero |
| gh_o | output | 1 | High-side gate command |
| gl_o | output | 1 | Low-side gate command |

## Verification
The checker assumes that all inputs are synchronous to clk_i and stable at each rising edge. It also assumes that HOLDOFF_CYC and DEAD_CYC are at least one, because the dead-time property looks two cycles back. The bench changes inputs only on falling edges. Its random phase holds each level for runs of random length, so that mid runs both shorter and longer than the hold-off occur. It pulses the zero-crossing flag, toggles the mode input and drops the enable at random points, and every such change stays on a falling edge.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_ALT  = 2'b11
  } lvl_e;
endpackage

// File: rtl/tgc_level_track.sv
module tgc_level_track
  import tgc_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] level_i,
  output logic       phase_hi_o,
  output logic       parked_o
);
  localparam int unsigned CNT_W = (HOLDOFF_CYC > 1) ? $clog2(HOLDOFF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLDOFF_CYC - 1);

  logic [CNT_W-1:0] mid_cnt_q;
  logic phase_q, parked_q;
  logic is_hi, is_lo;

  assign is_hi = (lvl_e'(level_i) == LVL_HIGH);
  assign is_lo = (lvl_e'(level_i) == LVL_LOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_cnt_q <= '0;
      phase_q   <= 1'b0;
      parked_q  <= 1'b1;
    end else if (is_hi) begin
      mid_cnt_q <= '0;
      phase_q   <= 1'b1;
      parked_q  <= 1'b0;
    end else if (is_lo) begin
      mid_cnt_q <= '0;
      phase_q   <= 1'b0;
    end else if (mid_cnt_q == LAST) begin
      parked_q  <= 1'b1;
    end else begin
      mid_cnt_q <= mid_cnt_q + 1'b1;
    end
  end

  assign phase_hi_o = phase_q;
  assign parked_o   = parked_q;
endmodule

// File: rtl/tgc_zc_latch.sv
module tgc_zc_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_hi_i,
  input  logic phase_hi_i,
  input  logic de_en_ni,
  input  logic zero_cross_i,
  output logic cut_o
);
  logic cut_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cut_q <= 1'b0;
    else if (level_hi_i || de_en_ni)     cut_q <= 1'b0;
    else if (!phase_hi_i && zero_cross_i) cut_q <= 1'b1;
  end

  assign cut_o = cut_q;
endmodule

// File: rtl/tgc_dead_time.sv
module tgc_dead_time #(
  parameter int unsigned DEAD_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_hi_i,
  input  logic req_lo_i,
  output logic gh_o,
  output logic gl_o
);
  localparam int unsigned W = $clog2(DEAD_CYC + 1) + 1;
  localparam logic [W-1:0] FULL = W'(DEAD_CYC);

  logic [W-1:0] idle_q;
  logic [1:0]   req, gate;
  logic         both_off, ready;

  assign req      = {req_lo_i, req_hi_i};
  assign both_off = (gate == 2'b00);
  assign ready    = both_off && (idle_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          idle_q <= '0;
    else if (!both_off)   idle_q <= '0;
    else if (idle_q != FULL) idle_q <= idle_q + 1'b1;
  end

  for (genvar g = 0; g < 2; g++) begin : g_gate
    logic on_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) on_q <= 1'b0;
      else         on_q <= req[g] && (on_q || ready);
    end
    assign gate[g] = on_q;
  end

  assign gh_o = gate[0];
  assign gl_o = gate[1];
endmodule

// File: rtl/tgc_gate_ctrl.sv
module tgc_gate_ctrl
  import tgc_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC = 8,
  parameter int unsigned DEAD_CYC    = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] level_i,
  input  logic       enable_i,
  input  logic       de_en_ni,
  input  logic       zero_cross_i,
  output logic       gh_o,
  output logic       gl_o
);
  logic phase_hi, parked, cut, req_hi, req_lo;

  tgc_level_track #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_level (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (level_i),
    .phase_hi_o (phase_hi),
    .parked_o   (parked)
  );

  tgc_zc_latch u_zc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .level_hi_i   (lvl_e'(level_i) == LVL_HIGH),
    .phase_hi_i   (phase_hi),
    .de_en_ni     (de_en_ni),
    .zero_cross_i (zero_cross_i),
    .cut_o        (cut)
  );

  assign req_hi = enable_i && !parked && phase_hi;
  assign req_lo = enable_i && !parked && !phase_hi && !(!de_en_ni && cut);

  tgc_dead_time #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_hi_i (req_hi),
    .req_lo_i (req_lo),
    .gh_o     (gh_o),
    .gl_o     (gl_o)
  );
endmodule

// File: rtl/tgc_gate_ctrl_chk.sv
module tgc_gate_ctrl_chk
  import tgc_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC = 8,
  parameter int unsigned DEAD_CYC    = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] level_i,
  input logic       enable_i,
  input logic       de_en_ni,
  input logic       zero_cross_i,
  input logic       gh_o,
  input logic       gl_o
);
  localparam int unsigned MW = $clog2(HOLDOFF_CYC + 2) + 1;
  localparam logic [MW-1:0] MLIM = MW'(HOLDOFF_CYC + 1);

  logic [MW-1:0] mid_run_q;
  logic seen_hi_q, is_mid;

  assign is_mid = (level_i == 2'b01) || (level_i == 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_run_q <= '0;
      seen_hi_q <= 1'b0;
    end else begin
      if (!is_mid)              mid_run_q <= '0;
      else if (mid_run_q != MLIM) mid_run_q <= mid_run_q + 1'b1;
      if (level_i == 2'b10)     seen_hi_q <= 1'b1;
    end
  end

  a_r8_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gh_o && gl_o));

  a_r7_disable_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!gh_o && !gl_o));

  a_r2_holdoff_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_run_q == MLIM) |-> (!gh_o && !gl_o));

  a_r4_parked_from_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_hi_q |-> (!gh_o && !gl_o));

  a_r9_gh_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gh_o) |-> (!$past(gl_o) && !$past(gl_o, 2)));

  a_r9_gl_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gl_o) |-> (!$past(gh_o) && !$past(gh_o, 2)));

  a_r6_zc_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!de_en_ni && zero_cross_i && level_i == 2'b00 && $past(level_i) == 2'b00)
      |=> ##1 (!gl_o || $past(de_en_ni)));
endmodule

bind tgc_gate_ctrl tgc_gate_ctrl_chk #(
  .HOLDOFF_CYC(HOLDOFF_CYC),
  .DEAD_CYC   (DEAD_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .level_i      (level_i),
  .enable_i     (enable_i),
  .de_en_ni     (de_en_ni),
  .zero_cross_i (zero_cross_i),
  .gh_o         (gh_o),
  .gl_o         (gl_o)
);

// File: tb/tgc_gate_ctrl_tb.sv
module tgc_gate_ctrl_tb;
  localparam int HOLD = 8;
  localparam int DEAD = 3;
  localparam logic [1:0] LO = 2'b00, MID = 2'b01, HI = 2'b10, ALT = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] level = LO;
  logic en = 1'b1, de_n = 1'b1, zc = 1'b0;
  logic gh, gl;
  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  tgc_gate_ctrl #(.HOLDOFF_CYC(HOLD), .DEAD_CYC(DEAD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .level_i(level), .enable_i(en),
    .de_en_ni(de_n), .zero_cross_i(zc), .gh_o(gh), .gl_o(gl)
  );

  // reference model of the requirements
  bit m_park, m_phase, m_cut, m_gh, m_gl;
  int m_mid, m_idle;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_park = 1; m_phase = 0; m_cut = 0; m_gh = 0; m_gl = 0; m_mid = 0; m_idle = 0;
    end else begin
      bit rh, rl, off, ngh, ngl;
      rh  = en && !m_park && m_phase;
      rl  = en && !m_park && !m_phase && !(!de_n && m_cut);
      off = !m_gh && !m_gl;
      ngh = rh && (m_gh || (off && m_idle == DEAD));
      ngl = rl && (m_gl || (off && m_idle == DEAD));
      m_idle = off ? ((m_idle < DEAD) ? m_idle + 1 : m_idle) : 0;
      if (level == HI || de_n) m_cut = 0;
      else if (!m_phase && zc) m_cut = 1;
      if (level == HI) begin m_phase = 1; m_park = 0; m_mid = 0; end
      else if (level == LO) begin m_phase = 0; m_mid = 0; end
      else if (m_mid == HOLD - 1) m_park = 1;
      else m_mid++;
      m_gh = ngh; m_gl = ngl;
    end
  end

  task automatic chk(string tag, logic gh_e, logic gl_e);
    checks++;
    if (gh !== gh_e || gl !== gl_e) begin
      errors++;
      $display("FAIL %s: gh/gl actual %b%b expected %b%b at %0t", tag, gh, gl, gh_e, gl_e, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      if (gh && gl) chk("R8", 1'b0, 1'b0);
      else if (!en) chk("R7", m_gh, m_gl);
      else if (m_park) chk("R3", m_gh, m_gl);
      else if (!de_n) chk("R6", m_gh, m_gl);
      else chk("R1", m_gh, m_gl);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    step(3);
    chk("R4 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    step(20);
    chk("R4 low after reset stays parked", 1'b0, 1'b0);
    level = HI; step(10);
    chk("R1 high phase", 1'b1, 1'b0);
    // dead gap measurement
    begin
      int gap = 0;
      level = LO;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (!gh && !gl) gap++;
        if (gl) break;
      end
      checks++;
      if (gap != DEAD + 1) begin
        errors++;
        $display("FAIL R9: gap actual %0d expected %0d", gap, DEAD + 1);
      end
    end
    step(5);
    chk("R1 low phase", 1'b0, 1'b1);
    // short mid run then high: no park
    level = HI; step(10);
    level = ALT; step(HOLD - 1);
    level = HI; step(3);
    chk("R2 short mid run keeps switching", 1'b1, 1'b0);
    level = MID; step(HOLD + 3);
    chk("R2 long mid run parks", 1'b0, 1'b0);
    level = LO; step(12);
    chk("R3 low does not exit park", 1'b0, 1'b0);
    level = HI; step(4);
    chk("R3 high exits park", 1'b1, 1'b0);
    // continuous conduction ignores zero cross
    de_n = 1'b1; level = LO; step(8);
    zc = 1'b1; step(3); zc = 1'b0; step(3);
    chk("R5 ccm keeps gl", 1'b0, 1'b1);
    // diode emulation
    level = HI; step(8);
    de_n = 1'b0; level = LO; step(8);
    chk("R6 gl before zero cross", 1'b0, 1'b1);
    zc = 1'b1; step(1); zc = 1'b0; step(1);
    chk("R6 gl cut", 1'b0, 1'b0);
    step(6);
    chk("R6 cut latched", 1'b0, 1'b0);
    level = HI; step(8); level = LO; step(8);
    chk("R6 cut cleared by high", 1'b0, 1'b1);
    de_n = 1'b1;
    // enable
    en = 1'b0; step(2);
    chk("R7 disabled", 1'b0, 1'b0);
    en = 1'b1; step(8);
    chk("R7 state retained", 1'b0, 1'b1);
    // random phase
    for (int n = 0; n < 300; n++) begin
      int r = $urandom % 8;
      level = (r < 3) ? HI : (r < 6) ? LO : ((r == 6) ? MID : ALT);
      if ($urandom % 6 == 0) de_n = ~de_n;
      en = ($urandom % 12 != 0);
      for (int k = 0, len = 1 + $urandom % 14; k < len; k++) begin
        zc = ($urandom % 5 == 0);
        @(negedge clk);
      end
    end
    zc = 1'b0; en = 1'b1; step(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule